// File: doc/BRIEF.md
# Multi-lane eye-scan request controller

This block sits between a software-visible request bit and the statistical eye-scan engines of a group of serial lanes. Software writes a request together with a lane select. A select value equal to a lane index aims the scan at that lane alone, and the all-ones select value aims it at every lane. The block then pulses a start to the chosen lanes and tracks their completion. When every chosen lane is done, it clears the request bit by itself and latches one combined error count.

Writing the request bit back to zero while a scan runs stops the scan. The block sends an abort pulse to the chosen lanes and sets a sticky flag that tells software the last scan was cut short. For a broadcast, the stored result is the bitwise OR of all lane counts. A zero result therefore means that no lane saw a single error.

Top module: `es_req_ctrl`

## Requirements
- R1: Out of reset, req_bit, busy, aborted, err_result, lane_start and lane_abort are all zero.
- R2: A write with wr_req=1 and a valid select, accepted while not busy, makes req_bit and busy 1 on the next cycle. On that cycle lane_start carries the selected lane mask for exactly one cycle. A select value of 0..NUM_LANES-1 selects that lane, and the all-ones value selects every lane.
- R3: A write with wr_req=1 and a select that is neither a lane index nor all ones is ignored: no start pulse is sent and req_bit stays 0.
- R4: In a single-lane scan, the cycle after that lane raises lane_done, req_bit and busy fall, aborted reads 0, and err_result equals that lane's count. lane_done from unselected lanes has no effect.
- R5: In a broadcast scan, completion waits until every lane has raised lane_done at least once since the start. The lanes need not report in the same cycle.
- R6: A broadcast result is the bitwise OR of all lane error counts, so it reads zero only when every count is zero.
- R7: A write with wr_req=0 while busy drops req_bit and busy on the next cycle. On that cycle lane_abort carries the selected mask for one cycle and aborted becomes 1. lane_done arriving after the stop has no effect.
- R8: A write with wr_req=1 while busy is ignored: no new start is sent and the running selection is kept.
- R9: A write with wr_req=0 while not busy changes no output.
- R10: If the last required lane_done and a stop write fall in the same cycle, the completion wins. The scan ends normally with aborted 0, the result is latched, and no abort pulse is sent.
- R11: err_result holds its value while idle and is cleared to zero when a scan is accepted. aborted changes only when a scan ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_req | input | 1 | Written value of the request bit |
| wr_sel | input | SEL_W | Written lane select (all ones = broadcast) |
| req_bit | output | 1 | Read-back of the request bit |
| busy | output | 1 | A scan is running |
| aborted | output | 1 | Sticky: last scan was stopped by software |
| err_result | output | ERR_W | Combined error count of the last scan |
| lane_start | output | NUM_LANES | One-cycle start pulse per lane |
| lane_abort | output | NUM_LANES | One-cycle abort pulse per lane |
| lane_done | input | NUM_LANES | Per-lane scan completion |
| lane_err | input | NUM_LANES*ERR_W | Per-lane error counts, lane 0 in the low bits |

## Verification
Normal completion and a software stop can land on the same clock edge. The bench provokes this by driving a stop write in the very cycle that the only selected lane reports done. It judges the outcome at the ports on the following cycle: aborted must read 0, the lane count must appear as the result, and no abort pulse may be sent. The bench also checks the milder overlaps: partial broadcast completions, and start or stop writes that arrive while the block is busy or idle.

// File: rtl/es_pkg.sv
package es_pkg;
    typedef enum logic [1:0] {
        ES_IDLE  = 2'd0,
        ES_RUN   = 2'd1,
        ES_DONE  = 2'd2,
        ES_ABORT = 2'd3
    } es_state_e;
endpackage

// File: rtl/es_lane_decode.sv
module es_lane_decode #(
    parameter int NUM_LANES = 4,
    parameter int SEL_W     = 8
) (
    input  logic [SEL_W-1:0]     sel,
    output logic [NUM_LANES-1:0] mask
);
    localparam logic [SEL_W-1:0] SEL_ALL = '1;

    logic bcast;
    assign bcast = (sel == SEL_ALL);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign mask[i] = bcast | (sel == SEL_W'(i));
    end
endmodule

// File: rtl/es_err_merge.sv
module es_err_merge #(
    parameter int NUM_LANES = 4,
    parameter int ERR_W     = 16
) (
    input  logic [NUM_LANES*ERR_W-1:0] lane_err,
    input  logic [NUM_LANES-1:0]       mask,
    output logic [ERR_W-1:0]           merged
);
    logic [ERR_W-1:0] chain [0:NUM_LANES];

    assign chain[0] = '0;
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_or
        assign chain[i+1] = chain[i] | (lane_err[i*ERR_W +: ERR_W] & {ERR_W{mask[i]}});
    end
    assign merged = chain[NUM_LANES];
endmodule

// File: rtl/es_done_gather.sv
module es_done_gather #(
    parameter int NUM_LANES = 4
) (
    input  logic [NUM_LANES-1:0] mask,
    input  logic [NUM_LANES-1:0] acc,
    input  logic [NUM_LANES-1:0] done,
    output logic [NUM_LANES-1:0] acc_next,
    output logic                 all_done
);
    assign acc_next = acc | (done & mask);
    assign all_done = (acc_next == mask);
endmodule

// File: rtl/es_req_ctrl.sv
module es_req_ctrl
    import es_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int ERR_W     = 16,
    parameter int SEL_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_req,
    input  logic [SEL_W-1:0]           wr_sel,
    output logic                       req_bit,
    output logic                       busy,
    output logic                       aborted,
    output logic [ERR_W-1:0]           err_result,
    output logic [NUM_LANES-1:0]       lane_start,
    output logic [NUM_LANES-1:0]       lane_abort,
    input  logic [NUM_LANES-1:0]       lane_done,
    input  logic [NUM_LANES*ERR_W-1:0] lane_err
);
    typedef struct packed {
        es_state_e            st;
        logic                 req;
        logic                 aborted;
        logic [NUM_LANES-1:0] mask;
        logic [NUM_LANES-1:0] dacc;
        logic [NUM_LANES-1:0] start;
        logic [NUM_LANES-1:0] abrt;
        logic [ERR_W-1:0]     res;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:      ES_IDLE,
        req:     1'b0,
        aborted: 1'b0,
        mask:    '0,
        dacc:    '0,
        start:   '0,
        abrt:    '0,
        res:     '0
    };

    regs_t r_d, r_q;

    logic [NUM_LANES-1:0] sel_mask;
    logic                 sel_valid;
    logic [ERR_W-1:0]     merged;
    logic [NUM_LANES-1:0] acc_next;
    logic                 all_done;

    es_lane_decode #(.NUM_LANES(NUM_LANES), .SEL_W(SEL_W)) u_decode (
        .sel  (wr_sel),
        .mask (sel_mask)
    );

    assign sel_valid = |sel_mask;

    es_err_merge #(.NUM_LANES(NUM_LANES), .ERR_W(ERR_W)) u_merge (
        .lane_err (lane_err),
        .mask     (r_q.mask),
        .merged   (merged)
    );

    es_done_gather #(.NUM_LANES(NUM_LANES)) u_gather (
        .mask     (r_q.mask),
        .acc      (r_q.dacc),
        .done     (lane_done),
        .acc_next (acc_next),
        .all_done (all_done)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = '0;
        r_d.abrt  = '0;
        case (r_q.st)
            ES_RUN: begin
                r_d.dacc = acc_next;
                if (all_done) begin
                    // completion wins over a stop written in the same cycle
                    r_d.st      = ES_DONE;
                    r_d.req     = 1'b0;
                    r_d.aborted = 1'b0;
                    r_d.res     = merged;
                end else if (wr_en && !wr_req) begin
                    r_d.st      = ES_ABORT;
                    r_d.req     = 1'b0;
                    r_d.aborted = 1'b1;
                    r_d.abrt    = r_q.mask;
                end
            end
            default: begin
                r_d.st = ES_IDLE;
                if (wr_en && wr_req && sel_valid) begin
                    r_d.st    = ES_RUN;
                    r_d.req   = 1'b1;
                    r_d.mask  = sel_mask;
                    r_d.dacc  = '0;
                    r_d.start = sel_mask;
                    r_d.res   = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_bit    = r_q.req;
    assign busy       = (r_q.st == ES_RUN);
    assign aborted    = r_q.aborted;
    assign err_result = r_q.res;
    assign lane_start = r_q.start;
    assign lane_abort = r_q.abrt;
endmodule

// File: rtl/es_req_ctrl_chk.sv
module es_req_ctrl_chk #(
    parameter int NUM_LANES = 4,
    parameter int ERR_W     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_bit,
    input logic                 busy,
    input logic                 aborted,
    input logic [ERR_W-1:0]     err_result,
    input logic [NUM_LANES-1:0] lane_start,
    input logic [NUM_LANES-1:0] lane_abort
);
    assert_start_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_start) |=> (lane_start == '0));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_start) |-> (busy && req_bit));

    assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_bit |-> busy);

    assert_normal_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !(|lane_abort)) |-> !aborted);

    assert_abort_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_abort) |-> (aborted && !busy && !req_bit));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((|lane_start) && (|lane_abort)));

    assert_abort_only_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_abort) |-> $past(busy));

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !(|lane_start)) |-> $stable(err_result));
endmodule

bind es_req_ctrl es_req_ctrl_chk #(.NUM_LANES(NUM_LANES), .ERR_W(ERR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_bit    (req_bit),
    .busy       (busy),
    .aborted    (aborted),
    .err_result (err_result),
    .lane_start (lane_start),
    .lane_abort (lane_abort)
);

// File: tb/tb_es_req_ctrl.sv
module tb_es_req_ctrl;
    localparam int N  = 4;
    localparam int EW = 16;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_req = 1'b0;
    logic [SW-1:0] wr_sel = '0;
    logic          req_bit, busy, aborted;
    logic [EW-1:0] err_result;
    logic [N-1:0]  lane_start, lane_abort;
    logic [N-1:0]  lane_done = '0;
    logic [N*EW-1:0] lane_err = '0;

    es_req_ctrl #(.NUM_LANES(N), .ERR_W(EW), .SEL_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_req(wr_req), .wr_sel(wr_sel),
        .req_bit(req_bit), .busy(busy), .aborted(aborted), .err_result(err_result),
        .lane_start(lane_start), .lane_abort(lane_abort),
        .lane_done(lane_done), .lane_err(lane_err)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            stamp;
        string         tag;
        logic          req;
        logic          bsy;
        logic          ab;
        logic [EW-1:0] res;
        logic [N-1:0]  st;
        logic [N-1:0]  abt;
    } exp_t;

    exp_t sb[$];

    // driver side: expectation for the next sampling point
    task automatic expect_next(string tag, logic rq, logic bs, logic ab,
                               logic [EW-1:0] res, logic [N-1:0] st, logic [N-1:0] abt);
        exp_t e;
        e.stamp = cyc + 1;
        e.tag = tag; e.req = rq; e.bsy = bs; e.ab = ab;
        e.res = res; e.st = st; e.abt = abt;
        sb.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
        wr_en = 1'b0;
        lane_done = '0;
    endtask

    task automatic write(logic rq, logic [SW-1:0] sel);
        wr_en = 1'b1; wr_req = rq; wr_sel = sel;
    endtask

    task automatic set_err(int lane, logic [EW-1:0] v);
        lane_err[lane*EW +: EW] = v;
    endtask

    // monitor side
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].stamp <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.stamp != cyc || req_bit !== e.req || busy !== e.bsy || aborted !== e.ab ||
                err_result !== e.res || lane_start !== e.st || lane_abort !== e.abt) begin
                errors++;
                $display("FAIL %s cyc %0d: got req=%b busy=%b ab=%b res=%h st=%b abt=%b exp req=%b busy=%b ab=%b res=%h st=%b abt=%b",
                         e.tag, cyc, req_bit, busy, aborted, err_result, lane_start, lane_abort,
                         e.req, e.bsy, e.ab, e.res, e.st, e.abt);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_next("R1", 0, 0, 0, 16'h0000, 4'b0000, 4'b0000); step();
        // R3 invalid select ignored
        write(1, 8'd5);
        expect_next("R3", 0, 0, 0, 16'h0000, 4'b0000, 4'b0000); step();
        expect_next("R3", 0, 0, 0, 16'h0000, 4'b0000, 4'b0000); step();
        // R2 single-lane start on lane 2
        set_err(2, 16'h00A5);
        write(1, 8'd2);
        expect_next("R2", 1, 1, 0, 16'h0000, 4'b0100, 4'b0000); step();
        expect_next("R2", 1, 1, 0, 16'h0000, 4'b0000, 4'b0000); step();
        // R8 start while busy ignored
        write(1, 8'd0);
        expect_next("R8", 1, 1, 0, 16'h0000, 4'b0000, 4'b0000); step();
        // R4 unselected lane done ignored
        set_err(0, 16'hFFFF);
        lane_done = 4'b0001;
        expect_next("R4", 1, 1, 0, 16'h0000, 4'b0000, 4'b0000); step();
        // R4 selected lane done completes
        lane_done = 4'b0100;
        expect_next("R4", 0, 0, 0, 16'h00A5, 4'b0000, 4'b0000); step();
        // R11 result held while idle
        expect_next("R11", 0, 0, 0, 16'h00A5, 4'b0000, 4'b0000); step();
        // R9 stop while idle has no effect
        write(0, 8'd2);
        expect_next("R9", 0, 0, 0, 16'h00A5, 4'b0000, 4'b0000); step();
        // R5/R6 broadcast with staggered completions
        set_err(0, 16'h0001); set_err(1, 16'h0000); set_err(2, 16'h0100); set_err(3, 16'h0000);
        write(1, 8'hFF);
        expect_next("R11", 1, 1, 0, 16'h0000, 4'b1111, 4'b0000); step();
        lane_done = 4'b0011;
        expect_next("R5", 1, 1, 0, 16'h0000, 4'b0000, 4'b0000); step();
        lane_done = 4'b0100;
        expect_next("R5", 1, 1, 0, 16'h0000, 4'b0000, 4'b0000); step();
        lane_done = 4'b1000;
        expect_next("R6", 0, 0, 0, 16'h0101, 4'b0000, 4'b0000); step();
        // R6 broadcast with all counts zero
        set_err(0, 16'h0000); set_err(2, 16'h0000);
        write(1, 8'hFF);
        expect_next("R6", 1, 1, 0, 16'h0000, 4'b1111, 4'b0000); step();
        lane_done = 4'b1111;
        expect_next("R6", 0, 0, 0, 16'h0000, 4'b0000, 4'b0000); step();
        // R7 stop a running scan on lane 1
        set_err(1, 16'h7777);
        write(1, 8'd1);
        expect_next("R7", 1, 1, 0, 16'h0000, 4'b0010, 4'b0000); step();
        write(0, 8'd1);
        expect_next("R7", 0, 0, 1, 16'h0000, 4'b0000, 4'b0010); step();
        expect_next("R7", 0, 0, 1, 16'h0000, 4'b0000, 4'b0000); step();
        lane_done = 4'b0010;
        expect_next("R7", 0, 0, 1, 16'h0000, 4'b0000, 4'b0000); step();
        // R11 aborted flag sticky across a new start
        set_err(0, 16'h0033);
        write(1, 8'd0);
        expect_next("R11", 1, 1, 1, 16'h0000, 4'b0001, 4'b0000); step();
        // R10 completion and stop in the same cycle
        write(0, 8'd0);
        lane_done = 4'b0001;
        expect_next("R10", 0, 0, 0, 16'h0033, 4'b0000, 4'b0000); step();
        expect_next("R10", 0, 0, 0, 16'h0033, 4'b0000, 4'b0000); step();
        repeat (3) step();
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expectations left unchecked", sb.size());
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule